// File: doc/BRIEF.md
# Two-Stage Command Dispatch Controller

This block takes commands from a host processor through a register write port and hands each one to one of four execution units. A command goes first into a host-side holding register. Hardware then moves it into a shadow stage, which holds the command that is running. The host cannot write the shadow stage. A decoder between the two stages turns the upper bits of the incoming command into a one-hot unit select. The lower bits are an opcode that is passed through to the selected unit.

Commands fall into two classes. A length-limited command ends when its unit reports done. An unlimited command keeps running until the host writes a newer command. When that happens, the controller asserts stop to the running unit and waits for that unit to report idle before it loads the new command. The host paces its writes with a write-enable flag. The flag drops while a command waits in the holding register and rises when that command enters the shadow stage. A write made while the flag is low is dropped and sets a sticky overflow bit, which a status read clears. A read-only debug output always shows the content of the shadow stage.

Top module: `cmd_dispatch`

## Requirements
- R1: After reset, both stages hold the no-operation code 8'h00, the write-enable flag reads 1, overflow reads 0, and no unit select, stop or start is asserted.
- R2: A host write while the write-enable flag is 1 is captured, and the flag reads 0 from the next cycle until that command has moved into the shadow stage.
- R3: A host write while the flag is 0 leaves both stages unchanged and sets overflow in the next cycle. Overflow stays set until a status read. A status read clears it in the next cycle, except when a dropped write occurs in the same cycle, which keeps it set.
- R4: When the shadow stage is idle (holding no-operation), a pending command moves into it on the next clock edge, and the write-enable flag reads 1 again from then on.
- R5: The command's bits [7:6] select unit 0 to 3 as a one-hot unit_sel, held for as long as the command runs. Bits [5:0] appear on unit_op. The code 8'h00 selects no unit.
- R6: Opcode bit 5 set marks an unlimited command. Opcode bit 5 clear marks a length-limited command.
- R7: A length-limited command ends on a clock edge where the done bit of its own unit is high. The shadow stage then takes the pending command, or 8'h00 if none is waiting. Done bits of other units have no effect.
- R8: An unlimited command ignores done. Once a newer command is pending, stop is asserted to the running unit (one-hot, same bit as unit_sel) from the next cycle on. The handover happens on the first edge where that unit's idle bit is high.
- R9: Each load of a command other than 8'h00 into the shadow stage raises unit_start for exactly one cycle, the cycle after the load.
- R10: dbg_cmd always equals the command held in the shadow stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host command write strobe |
| host_cmd | input | 8 | Command word written by the host |
| host_stat_rd | input | 1 | Status read strobe; clears overflow |
| cmd_wr_ok | output | 1 | Write-enable flag: holding register is free |
| cmd_overflow | output | 1 | Sticky flag for a dropped write |
| dbg_cmd | output | 8 | Read-only view of the shadow stage |
| unit_sel | output | 4 | One-hot select of the running unit |
| unit_op | output | 6 | Opcode of the running command |
| unit_start | output | 1 | One-cycle pulse when a command starts |
| unit_stop | output | 4 | One-hot stop request to the running unit |
| unit_done | input | 4 | Per-unit completion of a length-limited command |
| unit_idle | input | 4 | Per-unit idle report after a stop |

## Verification
The bench uses the default parameters: an 8-bit command with a 2-bit unit field. This gives four units and a 6-bit opcode whose top bit sets the command class, so every unit and both classes occur within a few hundred random commands. With only four done and idle bits, done and idle pulses on the wrong unit are frequent. This exercises the rule that only the running unit's handshake counts. Idle is held low for long stretches, so stop waits of many cycles happen and dropped writes pile up during them.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam int DEF_CMD_W = 8;
  localparam int DEF_SEL_W = 2;

  typedef enum logic [1:0] {
    EX_IDLE = 2'd0,
    EX_RUN  = 2'd1,
    EX_STOP = 2'd2
  } exec_state_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode #(
  parameter int CMD_W = cmd_pkg::DEF_CMD_W,
  parameter int SEL_W = cmd_pkg::DEF_SEL_W
) (
  input  logic [CMD_W-1:0]         cmd,
  output logic [(1<<SEL_W)-1:0]    unit_hot,
  output logic [CMD_W-SEL_W-1:0]   op,
  output logic                     is_nop,
  output logic                     is_unlimited
);
  localparam int NUM_UNITS = 1 << SEL_W;
  localparam int OP_W      = CMD_W - SEL_W;

  function automatic logic [NUM_UNITS-1:0] field_to_hot(input logic [SEL_W-1:0] f);
    logic [NUM_UNITS-1:0] h;
    h = '0;
    h[f] = 1'b1;
    return h;
  endfunction

  function automatic logic class_unlimited(input logic [OP_W-1:0] o);
    return o[OP_W-1];
  endfunction

  always_comb begin
    is_nop       = (cmd == '0);
    op           = cmd[OP_W-1:0];
    is_unlimited = class_unlimited(cmd[OP_W-1:0]);
    unit_hot     = is_nop ? '0 : field_to_hot(cmd[CMD_W-1:OP_W]);
  end

  always_comb begin
    assert (is_nop || $onehot(unit_hot)) else $error("AST_DECODE_HOT failed"); // R5
  end
endmodule

// File: rtl/cmd_host_reg.sv
module cmd_host_reg #(
  parameter int CMD_W = cmd_pkg::DEF_CMD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_cmd,
  input  logic             stat_rd,
  input  logic             load_evt,
  output logic             pend,
  output logic [CMD_W-1:0] held_cmd,
  output logic             wr_ok,
  output logic             ovf
);
  logic accept_evt;
  logic reject_evt;
  logic pend_q;
  logic ovf_q;
  logic [CMD_W-1:0] cmd_q;

  assign accept_evt = wr_en & ~pend_q;
  assign reject_evt = wr_en &  pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cmd_q  <= '0;
    end else if (accept_evt) begin
      pend_q <= 1'b1;
      cmd_q  <= wr_cmd;
    end else if (load_evt) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_q <= 1'b0;
    else if (reject_evt) ovf_q <= 1'b1;
    else if (stat_rd)    ovf_q <= 1'b0;
  end

  assign pend     = pend_q;
  assign held_cmd = cmd_q;
  assign wr_ok    = ~pend_q;
  assign ovf      = ovf_q;

  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !wr_ok); // R2
  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> ovf); // R3
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> $stable(held_cmd)); // R3
  AST_LOAD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> wr_ok); // R4
  AST_LOAD_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> pend); // R4
endmodule

// File: rtl/cmd_exec_ctrl.sv
module cmd_exec_ctrl
  import cmd_pkg::*;
#(
  parameter int CMD_W = DEF_CMD_W,
  parameter int SEL_W = DEF_SEL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pend,
  input  logic [CMD_W-1:0]            held_cmd,
  input  logic [(1<<SEL_W)-1:0]       unit_done,
  input  logic [(1<<SEL_W)-1:0]       unit_idle,
  output logic                        load_evt,
  output logic [CMD_W-1:0]            shadow,
  output logic [(1<<SEL_W)-1:0]       sel,
  output logic [(1<<SEL_W)-1:0]       stop,
  output logic                        start,
  output logic [CMD_W-SEL_W-1:0]      op
);
  localparam int NUM_UNITS = 1 << SEL_W;
  localparam int OP_W      = CMD_W - SEL_W;

  exec_state_t          st_q;
  logic [CMD_W-1:0]     shadow_q;
  logic [NUM_UNITS-1:0] sel_q;
  logic                 unl_q;
  logic                 start_q;

  logic [NUM_UNITS-1:0] in_hot;
  logic [OP_W-1:0]      in_op;
  logic                 in_nop;
  logic                 in_unl;

  logic done_hit;
  logic idle_hit;
  logic finish_evt;
  logic preempt_evt;

  cmd_decode #(.CMD_W(CMD_W), .SEL_W(SEL_W)) u_dec (
    .cmd          (held_cmd),
    .unit_hot     (in_hot),
    .op           (in_op),
    .is_nop       (in_nop),
    .is_unlimited (in_unl)
  );

  assign done_hit    = |(unit_done & sel_q);
  assign idle_hit    = |(unit_idle & sel_q);
  assign finish_evt  = (st_q == EX_RUN) && !unl_q && done_hit;
  assign preempt_evt = (st_q == EX_RUN) && unl_q && pend;
  assign load_evt    = pend && ((st_q == EX_IDLE) || finish_evt ||
                                ((st_q == EX_STOP) && idle_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= EX_IDLE;
      shadow_q <= '0;
      sel_q    <= '0;
      unl_q    <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (load_evt) begin
        shadow_q <= held_cmd;
        sel_q    <= in_hot;
        unl_q    <= in_unl;
        st_q     <= in_nop ? EX_IDLE : EX_RUN;
        start_q  <= ~in_nop;
      end else if (finish_evt) begin
        shadow_q <= '0;
        sel_q    <= '0;
        unl_q    <= 1'b0;
        st_q     <= EX_IDLE;
      end else if (preempt_evt) begin
        st_q <= EX_STOP;
      end
    end
  end

  assign shadow = shadow_q;
  assign sel    = sel_q;
  assign stop   = (st_q == EX_STOP) ? sel_q : '0;
  assign start  = start_q;
  assign op     = shadow_q[OP_W-1:0];

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R5
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|stop && !load_evt) |=> |stop); // R8
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start); // R9
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_evt && !pend) |=> (shadow == '0)); // R7
  AST_UNLIMITED_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == EX_RUN) && unl_q && !pend) |=> $stable(shadow)); // R8
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch #(
  parameter int CMD_W = cmd_pkg::DEF_CMD_W,
  parameter int SEL_W = cmd_pkg::DEF_SEL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_wr,
  input  logic [CMD_W-1:0]            host_cmd,
  input  logic                        host_stat_rd,
  output logic                        cmd_wr_ok,
  output logic                        cmd_overflow,
  output logic [CMD_W-1:0]            dbg_cmd,
  output logic [(1<<SEL_W)-1:0]       unit_sel,
  output logic [CMD_W-SEL_W-1:0]      unit_op,
  output logic                        unit_start,
  output logic [(1<<SEL_W)-1:0]       unit_stop,
  input  logic [(1<<SEL_W)-1:0]       unit_done,
  input  logic [(1<<SEL_W)-1:0]       unit_idle
);
  logic             pend;
  logic [CMD_W-1:0] held_cmd;
  logic             load_evt;

  cmd_host_reg #(.CMD_W(CMD_W)) u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr),
    .wr_cmd   (host_cmd),
    .stat_rd  (host_stat_rd),
    .load_evt (load_evt),
    .pend     (pend),
    .held_cmd (held_cmd),
    .wr_ok    (cmd_wr_ok),
    .ovf      (cmd_overflow)
  );

  cmd_exec_ctrl #(.CMD_W(CMD_W), .SEL_W(SEL_W)) u_exec (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .held_cmd  (held_cmd),
    .unit_done (unit_done),
    .unit_idle (unit_idle),
    .load_evt  (load_evt),
    .shadow    (dbg_cmd),
    .sel       (unit_sel),
    .stop      (unit_stop),
    .start     (unit_start),
    .op        (unit_op)
  );

  AST_DBG_SEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_cmd == '0) |-> (unit_sel == '0)); // R10
endmodule

// File: tb/cmd_dispatch_bench.sv
`timescale 1ns/1ps
module cmd_dispatch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_cmd = 8'h00;
  logic       host_stat_rd = 1'b0;
  logic [3:0] unit_done = 4'h0;
  logic [3:0] unit_idle = 4'h0;
  logic       cmd_wr_ok, cmd_overflow, unit_start;
  logic [7:0] dbg_cmd;
  logic [3:0] unit_sel, unit_stop;
  logic [5:0] unit_op;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cmd_dispatch u_cmd_dispatch (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_cmd(host_cmd),
    .host_stat_rd(host_stat_rd), .cmd_wr_ok(cmd_wr_ok), .cmd_overflow(cmd_overflow),
    .dbg_cmd(dbg_cmd), .unit_sel(unit_sel), .unit_op(unit_op), .unit_start(unit_start),
    .unit_stop(unit_stop), .unit_done(unit_done), .unit_idle(unit_idle)
  );

  // Reference model: 0 = nothing running, 1 = running, 2 = stop requested
  logic       m_pend = 1'b0;
  logic [7:0] m_hold = 8'h00;
  logic [7:0] m_shadow = 8'h00;
  int         m_mode = 0;
  logic       m_start = 1'b0;
  logic       m_ovf = 1'b0;

  function automatic logic [3:0] exp_hot(input logic [7:0] c);
    if (c == 8'h00) return 4'h0;
    return 4'b0001 << c[7:6];
  endfunction
  function automatic logic exp_unlimited(input logic [7:0] c);
    return c[5];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend <= 1'b0; m_hold <= 8'h00; m_shadow <= 8'h00;
      m_mode <= 0; m_start <= 1'b0; m_ovf <= 1'b0;
    end else begin
      logic hd, hi, ld, fin;
      hd  = |(unit_done & exp_hot(m_shadow));
      hi  = |(unit_idle & exp_hot(m_shadow));
      fin = (m_mode == 1) && !exp_unlimited(m_shadow) && hd;
      ld  = m_pend && (m_mode == 0 || fin || (m_mode == 2 && hi));
      m_start <= ld && (m_hold != 8'h00);
      if (host_wr && m_pend) m_ovf <= 1'b1;
      else if (host_stat_rd) m_ovf <= 1'b0;
      if (host_wr && !m_pend) begin m_pend <= 1'b1; m_hold <= host_cmd; end
      else if (ld) m_pend <= 1'b0;
      if (ld) begin
        m_shadow <= m_hold;
        m_mode   <= (m_hold == 8'h00) ? 0 : 1;
      end else if (fin) begin
        m_shadow <= 8'h00; m_mode <= 0;
      end else if (m_mode == 1 && exp_unlimited(m_shadow) && m_pend) begin
        m_mode <= 2;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 write flag", {31'd0, cmd_wr_ok}, {31'd0, !m_pend});
    check("R3 overflow", {31'd0, cmd_overflow}, {31'd0, m_ovf});
    check("R4/R7/R10 shadow", {24'd0, dbg_cmd}, {24'd0, m_shadow});
    check("R5 select", {28'd0, unit_sel}, {28'd0, (m_mode != 0) ? exp_hot(m_shadow) : 4'h0});
    check("R5 opcode", {26'd0, unit_op}, {26'd0, m_shadow[5:0]});
    check("R6/R8 stop", {28'd0, unit_stop}, {28'd0, (m_mode == 2) ? exp_hot(m_shadow) : 4'h0});
    check("R9 start", {31'd0, unit_start}, {31'd0, m_start});
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    void'($urandom(32'h5EED_0101));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 wr_ok", {31'd0, cmd_wr_ok}, 32'd1);
    check("R1 overflow", {31'd0, cmd_overflow}, 32'd0);
    check("R1 shadow", {24'd0, dbg_cmd}, 32'd0);
    check("R1 select/stop/start", {23'd0, unit_sel, unit_stop, unit_start}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: unlimited command with idle held low, then a preempting write
    host_wr = 1'b1; host_cmd = 8'hA5;
    @(negedge clk); compare_all(); host_wr = 1'b0;
    @(negedge clk); compare_all();
    host_wr = 1'b1; host_cmd = 8'h47; unit_done = 4'hF;
    @(negedge clk); compare_all();
    host_wr = 1'b1; host_cmd = 8'hC1; // dropped, sets overflow (R3)
    @(negedge clk); compare_all(); host_wr = 1'b0; unit_done = 4'h0;
    unit_idle = 4'b1011; // other units idle, unit 2 not (R8)
    repeat (3) begin @(negedge clk); compare_all(); end
    unit_idle = 4'b0100;
    @(negedge clk); compare_all(); unit_idle = 4'h0;
    unit_done = 4'b1101; // done on units other than 1 (R7)
    repeat (2) begin @(negedge clk); compare_all(); end
    unit_done = 4'b0010;
    @(negedge clk); compare_all(); unit_done = 4'h0;
    host_stat_rd = 1'b1;
    @(negedge clk); compare_all(); host_stat_rd = 1'b0;
    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        @(negedge clk);
        compare_all();
        host_wr      = ($urandom % 100) < ((ph % 2) ? 40 : 12);
        host_cmd     = (($urandom % 8) == 0) ? 8'h00 : 8'($urandom);
        host_stat_rd = ($urandom % 16) == 0;
        unit_done    = 4'($urandom) & 4'($urandom);
        unit_idle    = (ph >= 2) ? (4'($urandom) & 4'($urandom) & 4'($urandom)) : 4'($urandom);
      end
    end
    @(negedge clk); compare_all();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule